// File: doc/BRIEF.md
# Hybrid DRAM Backup Controller

This block sequences a memory module that keeps DRAM contents through a loss of host power by copying them into NAND flash. In normal operation the host owns the DRAM through closed isolation switches. A filtered, active-low backup request from the platform starts a save. The controller waits for the host to confirm that its caches are flushed and the DRAM is in self-refresh. It then opens the isolation switches and streams every DRAM word, check bits included, into NAND. The whole save must finish inside a hold-up cycle budget.

When host power is good again, the controller either streams the NAND image back into DRAM, or goes straight to normal operation if no complete image was saved. A 5-bit status word reports the mode, the image-valid flag, busy and a timeout error at all times.

Both copy paths are valid/ready streams carrying a (DATA_W+ECC_W)-bit word. Within the active direction the controller forwards the source word, source valid and sink ready combinationally, so sink back-pressure stalls the source in the same cycle. A beat moves only on a cycle where source valid and sink ready are both high. The inactive direction sees valid and ready held low.

Top module: `dram_backup_ctrl`

## Requirements
- R1: status[1:0] is the mode (00 normal, 01 save, 10 restore, 11 hold), status[2] image valid, status[3] busy, status[4] error. After reset the mode is hold, valid/busy/error are 0 and iso_open is 1.
- R2: save_req_n is taken through a two-flop synchronizer and acts only when it is sampled low on at least two consecutive rising edges. A request low for a single clock cycle has no effect.
- R3: An accepted request in normal mode raises busy and clears error. The mode stays 00 and iso_open stays 0 until sr_ack is high. The next cycle the mode becomes save, iso_open is 1 and valid is cleared.
- R4: In save mode exactly WORDS words pass from the dram_rd stream to the nand_wr stream unmodified in all bits, including the check bits in [DATA_W+ECC_W-1:DATA_W], obeying back-pressure.
- R5: When the last word is accepted by nand_wr, the next cycle shows mode hold, valid 1 and busy 0.
- R6: The save budget is counted from the first busy cycle (cycle 0). If the last word has not moved by the end of cycle HOLDUP_CYCLES-1, the next cycle shows mode hold, error 1 and valid 0. A last word moved in cycle HOLDUP_CYCLES-1 is a success.
- R7: In hold mode, with pwr_good high and no accepted request, the controller enters restore if valid is 1 and otherwise enters normal mode with iso_open 0.
- R8: In restore mode exactly WORDS words pass from nand_rd to dram_wr unmodified in all bits. Afterwards the mode is normal, iso_open 0 and busy 0.
- R9: A request accepted during restore aborts the restore and enters save directly, without waiting for sr_ack. Valid keeps its value until that save ends.
- R10: nand_wr_valid and dram_rd_ready are high only in save mode. dram_wr_valid and nand_rd_ready are high only in restore mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| save_req_n | input | 1 | Asynchronous active-low backup request |
| pwr_good | input | 1 | Host power good |
| sr_ack | input | 1 | Host reports DRAM flushed and in self-refresh |
| iso_open | output | 1 | 1 = DRAM disconnected from host bus |
| dram_rd_valid | input | 1 | DRAM read stream valid |
| dram_rd_ready | output | 1 | DRAM read stream ready |
| dram_rd_data | input | DATA_W+ECC_W | DRAM word with check bits |
| nand_wr_valid | output | 1 | NAND write stream valid |
| nand_wr_ready | input | 1 | NAND write stream ready |
| nand_wr_data | output | DATA_W+ECC_W | Word to NAND |
| nand_rd_valid | input | 1 | NAND read stream valid |
| nand_rd_ready | output | 1 | NAND read stream ready |
| nand_rd_data | input | DATA_W+ECC_W | Word from NAND |
| dram_wr_valid | output | 1 | DRAM write stream valid |
| dram_wr_ready | input | 1 | DRAM write stream ready |
| dram_wr_data | output | DATA_W+ECC_W | Word to DRAM |
| status | output | 5 | {error, busy, valid, mode[1:0]} |

## Verification
Two functions can fall in the same cycle: the final word of a save and the expiry of the hold-up budget. The bench counts cycles from the first busy cycle and streams all but one word early. It then holds nand_wr_ready low and releases it only in cycle HOLDUP_CYCLES-1. The result must be a valid image with no error. A separate save where no words move must time out exactly one cycle after that cycle. Random patterns with random back-pressure are compared bit for bit, check bits included, in both directions.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
  typedef enum logic [2:0] {S_HOLD, S_NORMAL, S_ARM, S_SAVE, S_RESTORE} state_e;
  typedef enum logic [1:0] {
    M_NORMAL  = 2'b00,
    M_SAVE    = 2'b01,
    M_RESTORE = 2'b10,
    M_HOLD    = 2'b11
  } mode_e;
  typedef enum logic [1:0] {X_IDLE, X_SAVE, X_RESTORE} xdir_e;
  typedef struct packed {
    logic  err;
    logic  busy;
    logic  valid;
    mode_e mode;
  } status_t;
endpackage

// File: rtl/bkp_req_filter.sv
// Synchronizes the asynchronous request and demands two consecutive low samples.
module bkp_req_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_async,
  output logic req_ok
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= req_n_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign req_ok = !sync_q && !prev_q;
endmodule

// File: rtl/bkp_budget_timer.sv
// Counts cycles of an active save window; flags the last allowed cycle.
module bkp_budget_timer #(
  parameter int HOLDUP_CYCLES = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int TW = (HOLDUP_CYCLES > 2) ? $clog2(HOLDUP_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(HOLDUP_CYCLES - 1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     tmr_q <= '0;
    else if (start)                 tmr_q <= '0;
    else if (run && tmr_q != LAST)  tmr_q <= tmr_q + 1'b1;
  end

  assign expired = run && (tmr_q == LAST);
endmodule

// File: rtl/bkp_xfer_path.sv
// Steers the two copy streams and counts beats of the active direction.
module bkp_xfer_path
  import bkp_pkg::*;
#(
  parameter int WORD_W = 72,
  parameter int WORDS  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xdir_e             dir,
  input  logic              dram_rd_valid,
  output logic              dram_rd_ready,
  input  logic [WORD_W-1:0] dram_rd_data,
  output logic              nand_wr_valid,
  input  logic              nand_wr_ready,
  output logic [WORD_W-1:0] nand_wr_data,
  input  logic              nand_rd_valid,
  output logic              nand_rd_ready,
  input  logic [WORD_W-1:0] nand_rd_data,
  output logic              dram_wr_valid,
  input  logic              dram_wr_ready,
  output logic [WORD_W-1:0] dram_wr_data,
  output logic              last_beat
);
  localparam int CW = (WORDS > 2) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WORDS - 1);

  logic          save_on, rest_on, beat;
  logic [CW-1:0] cnt_q;

  assign save_on = (dir == X_SAVE);
  assign rest_on = (dir == X_RESTORE);

  // Words travel verbatim: data and check bits are never recomputed.
  assign nand_wr_valid = save_on & dram_rd_valid;
  assign dram_rd_ready = save_on & nand_wr_ready;
  assign nand_wr_data  = dram_rd_data;
  assign dram_wr_valid = rest_on & nand_rd_valid;
  assign nand_rd_ready = rest_on & dram_wr_ready;
  assign dram_wr_data  = nand_rd_data;

  assign beat = (save_on & dram_rd_valid & nand_wr_ready) |
                (rest_on & nand_rd_valid & dram_wr_ready);
  assign last_beat = beat && (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (beat)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dram_backup_ctrl.sv
module dram_backup_ctrl
  import bkp_pkg::*;
#(
  parameter int DATA_W        = 64,
  parameter int ECC_W         = 8,
  parameter int WORDS         = 4096,
  parameter int HOLDUP_CYCLES = 125000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    save_req_n,
  input  logic                    pwr_good,
  input  logic                    sr_ack,
  output logic                    iso_open,
  input  logic                    dram_rd_valid,
  output logic                    dram_rd_ready,
  input  logic [DATA_W+ECC_W-1:0] dram_rd_data,
  output logic                    nand_wr_valid,
  input  logic                    nand_wr_ready,
  output logic [DATA_W+ECC_W-1:0] nand_wr_data,
  input  logic                    nand_rd_valid,
  output logic                    nand_rd_ready,
  input  logic [DATA_W+ECC_W-1:0] nand_rd_data,
  output logic                    dram_wr_valid,
  input  logic                    dram_wr_ready,
  output logic [DATA_W+ECC_W-1:0] dram_wr_data,
  output logic [4:0]              status
);
  localparam int WORD_W = DATA_W + ECC_W;

  state_e  state_q, nxt;
  logic    valid_q, err_q;
  logic    req_ok, expired, last_beat, timer_run;
  logic    tmr_start, x_start, set_valid, clr_valid, set_err, clr_err;
  xdir_e   dir;
  status_t st;

  bkp_req_filter u_filt (
    .clk(clk), .rst_n(rst_n), .req_n_async(save_req_n), .req_ok(req_ok)
  );

  assign timer_run = (state_q == S_ARM) || (state_q == S_SAVE);

  bkp_budget_timer #(.HOLDUP_CYCLES(HOLDUP_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .run(timer_run), .expired(expired)
  );

  always_comb begin
    case (state_q)
      S_SAVE:    dir = X_SAVE;
      S_RESTORE: dir = X_RESTORE;
      default:   dir = X_IDLE;
    endcase
  end

  bkp_xfer_path #(.WORD_W(WORD_W), .WORDS(WORDS)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(x_start), .dir(dir),
    .dram_rd_valid(dram_rd_valid), .dram_rd_ready(dram_rd_ready), .dram_rd_data(dram_rd_data),
    .nand_wr_valid(nand_wr_valid), .nand_wr_ready(nand_wr_ready), .nand_wr_data(nand_wr_data),
    .nand_rd_valid(nand_rd_valid), .nand_rd_ready(nand_rd_ready), .nand_rd_data(nand_rd_data),
    .dram_wr_valid(dram_wr_valid), .dram_wr_ready(dram_wr_ready), .dram_wr_data(dram_wr_data),
    .last_beat(last_beat)
  );

  always_comb begin
    nxt       = state_q;
    tmr_start = 1'b0;
    x_start   = 1'b0;
    set_valid = 1'b0;
    clr_valid = 1'b0;
    set_err   = 1'b0;
    clr_err   = 1'b0;
    case (state_q)
      S_HOLD: begin
        if (pwr_good && !req_ok) begin
          if (valid_q) begin
            nxt     = S_RESTORE;
            x_start = 1'b1;
          end else begin
            nxt = S_NORMAL;
          end
        end
      end
      S_NORMAL: begin
        if (req_ok) begin
          nxt       = S_ARM;
          tmr_start = 1'b1;
          clr_err   = 1'b1;
        end
      end
      S_ARM: begin
        if (expired) begin
          nxt       = S_HOLD;
          set_err   = 1'b1;
          clr_valid = 1'b1;
        end else if (sr_ack) begin
          nxt       = S_SAVE;
          x_start   = 1'b1;
          clr_valid = 1'b1;
        end
      end
      S_SAVE: begin
        // A final beat in the last budget cycle counts as completion.
        if (last_beat) begin
          nxt       = S_HOLD;
          set_valid = 1'b1;
        end else if (expired) begin
          nxt       = S_HOLD;
          set_err   = 1'b1;
          clr_valid = 1'b1;
        end
      end
      S_RESTORE: begin
        if (req_ok) begin
          nxt       = S_SAVE;
          x_start   = 1'b1;
          tmr_start = 1'b1;
          clr_err   = 1'b1;
        end else if (last_beat) begin
          nxt = S_NORMAL;
        end
      end
      default: nxt = S_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HOLD;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      if (set_valid)      valid_q <= 1'b1;
      else if (clr_valid) valid_q <= 1'b0;
      if (set_err)        err_q <= 1'b1;
      else if (clr_err)   err_q <= 1'b0;
    end
  end

  always_comb begin
    st.valid = valid_q;
    st.err   = err_q;
    st.busy  = (state_q == S_ARM) || (state_q == S_SAVE) || (state_q == S_RESTORE);
    case (state_q)
      S_SAVE:    st.mode = M_SAVE;
      S_RESTORE: st.mode = M_RESTORE;
      S_HOLD:    st.mode = M_HOLD;
      default:   st.mode = M_NORMAL;
    endcase
  end

  assign status   = st;
  assign iso_open = (state_q == S_SAVE) || (state_q == S_RESTORE) || (state_q == S_HOLD);
endmodule

// File: rtl/bkp_ctrl_chk.sv
module bkp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] status,
  input logic       iso_open,
  input logic       nand_wr_valid,
  input logic       dram_rd_ready,
  input logic       dram_wr_valid,
  input logic       nand_rd_ready
);
  logic [1:0] mode;
  logic       valid, busy, err;
  assign mode  = status[1:0];
  assign valid = status[2];
  assign busy  = status[3];
  assign err   = status[4];

  p_iso_in_save_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> iso_open);

  p_busy_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 || mode == 2'b10) |-> busy);

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> !busy);

  p_valid_from_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(mode) == 2'b01));

  p_err_no_image_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !valid);

  p_restore_needs_image_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) == 2'b11) |-> valid);

  p_save_lane_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |-> (!nand_wr_valid && !dram_rd_ready));

  p_restore_lane_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |-> (!dram_wr_valid && !nand_rd_ready));
endmodule

bind dram_backup_ctrl bkp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .iso_open(iso_open),
  .nand_wr_valid(nand_wr_valid), .dram_rd_ready(dram_rd_ready),
  .dram_wr_valid(dram_wr_valid), .nand_rd_ready(nand_rd_ready)
);

// File: tb/dram_backup_ctrl_bench.sv
`timescale 1ns/1ps
module dram_backup_ctrl_bench;
  localparam int DW = 64, EW = 8, WW = DW + EW, NW = 16, BUD = 120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic save_req_n = 1'b1, pwr_good = 1'b0, sr_ack = 1'b0;
  logic iso_open;
  logic dram_rd_valid = 1'b0, dram_rd_ready;  logic [WW-1:0] dram_rd_data = '0;
  logic nand_wr_valid, nand_wr_ready = 1'b0;  logic [WW-1:0] nand_wr_data;
  logic nand_rd_valid = 1'b0, nand_rd_ready;  logic [WW-1:0] nand_rd_data = '0;
  logic dram_wr_valid, dram_wr_ready = 1'b0;  logic [WW-1:0] dram_wr_data;
  logic [4:0] status;

  int checks = 0, errors = 0;
  logic [WW-1:0] dram_img [NW];
  logic [WW-1:0] nand_img [NW];
  logic [WW-1:0] dram_back [NW];

  always #4 clk = ~clk;

  dram_backup_ctrl #(.DATA_W(DW), .ECC_W(EW), .WORDS(NW), .HOLDUP_CYCLES(BUD)) u_dram_backup_ctrl (
    .clk(clk), .rst_n(rst_n), .save_req_n(save_req_n), .pwr_good(pwr_good), .sr_ack(sr_ack),
    .iso_open(iso_open),
    .dram_rd_valid(dram_rd_valid), .dram_rd_ready(dram_rd_ready), .dram_rd_data(dram_rd_data),
    .nand_wr_valid(nand_wr_valid), .nand_wr_ready(nand_wr_ready), .nand_wr_data(nand_wr_data),
    .nand_rd_valid(nand_rd_valid), .nand_rd_ready(nand_rd_ready), .nand_rd_data(nand_rd_data),
    .dram_wr_valid(dram_wr_valid), .dram_wr_ready(dram_wr_ready), .dram_wr_data(dram_wr_data),
    .status(status)
  );

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] rnd_word();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[WW-1:0];
  endfunction

  task automatic new_image();
    for (int i = 0; i < NW; i++) dram_img[i] = rnd_word();
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wait_mode(input logic [1:0] m, input string rq);
    int n = 0;
    while (status[1:0] != m && n < 400) begin tick(); n++; end
    chk(status[1:0] == m, rq, status[1:0], m);
  endtask

  task automatic wait_busy(output bit seen);
    int n = 0;
    seen = 0;
    while (!status[3] && n < 20) begin tick(); n++; end
    seen = status[3];
  endtask

  // Streams DRAM image to the sink; bp selects random back-pressure.
  task automatic pump_save(input int n, input bit bp);
    int got = 0, idx = 0, guard = 0;
    while (got < n && guard < 4000) begin
      @(negedge clk); guard++;
      dram_rd_valid = bp ? ($urandom() % 4 != 0) : 1'b1;
      dram_rd_data  = dram_img[idx % NW];
      nand_wr_ready = bp ? ($urandom() % 3 != 0) : 1'b1;
      #1;
      if (nand_wr_valid && nand_wr_ready) begin nand_img[got % NW] = nand_wr_data; got++; end
      if (dram_rd_valid && dram_rd_ready) idx++;
    end
    @(negedge clk); dram_rd_valid = 1'b0; nand_wr_ready = 1'b0; #1;
    chk(got == n, "R4 save beats", got, n);
  endtask

  task automatic pump_restore(input int n);
    int got = 0, idx = 0, guard = 0;
    while (got < n && guard < 4000) begin
      @(negedge clk); guard++;
      nand_rd_valid = ($urandom() % 4 != 0);
      nand_rd_data  = nand_img[idx % NW];
      dram_wr_ready = ($urandom() % 3 != 0);
      #1;
      if (dram_wr_valid && dram_wr_ready) begin dram_back[got % NW] = dram_wr_data; got++; end
      if (nand_rd_valid && nand_rd_ready) idx++;
    end
    @(negedge clk); nand_rd_valid = 1'b0; dram_wr_ready = 1'b0; #1;
    chk(got == n, "R8 restore beats", got, n);
  endtask

  task automatic cmp_images(input string rq, input bit back);
    int bad = 0;
    for (int i = 0; i < NW; i++)
      if ((back ? dram_back[i] : nand_img[i]) !== dram_img[i]) bad++;
    chk(bad == 0, rq, bad, 0);
  endtask

  task automatic request_pulse(input int len);
    @(negedge clk); save_req_n = 1'b0;
    repeat (len) @(negedge clk);
    save_req_n = 1'b1; #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    int k;
    void'($urandom(32'd1234));
    repeat (3) tick();
    // R1 reset state
    chk(status == 5'b00011, "R1 reset status", status, 5'b00011);
    chk(iso_open == 1'b1, "R1 reset iso", iso_open, 1);
    rst_n = 1'b1;
    tick();
    // R7 power up without image: skip restore
    pwr_good = 1'b1;
    wait_mode(2'b00, "R7 no image to normal");
    chk(iso_open == 1'b0 && status[3] == 1'b0, "R7 bus connected", {iso_open, status[3]}, 0);

    // R2 single-cycle glitch ignored
    request_pulse(1);
    repeat (8) tick();
    chk(status[3:0] == 4'b0000, "R2 glitch ignored", status, 0);

    // R3 accepted request waits for self-refresh
    new_image();
    pwr_good = 1'b0;
    @(negedge clk); save_req_n = 1'b0;
    wait_busy(seen);
    chk(seen, "R2 two-cycle request accepted", seen, 1);
    repeat (4) tick();
    chk(status[1:0] == 2'b00 && !iso_open, "R3 wait for sr_ack", {status[1:0], iso_open}, 0);
    sr_ack = 1'b1;
    tick(); tick();
    chk(status[1:0] == 2'b01 && iso_open, "R3 save isolates", {status[1:0], iso_open}, 3'b011);
    chk(!dram_wr_valid && !nand_rd_ready, "R10 restore lane quiet in save", {dram_wr_valid, nand_rd_ready}, 0);
    save_req_n = 1'b1;
    sr_ack = 1'b0;
    pump_save(NW, 1'b1);
    chk(status == 5'b00111, "R5 save done status", status, 5'b00111);
    cmp_images("R4 save ECC bit-exact", 1'b0);
    repeat (5) tick();
    chk(status[1:0] == 2'b11, "R7 hold while power low", status[1:0], 2'b11);

    // R7/R8 restore on power return
    pwr_good = 1'b1;
    tick(); tick();
    chk(status[1:0] == 2'b10 && iso_open, "R7 restore entered", {status[1:0], iso_open}, 3'b101);
    chk(!nand_wr_valid && !dram_rd_ready, "R10 save lane quiet in restore", {nand_wr_valid, dram_rd_ready}, 0);
    pump_restore(NW);
    cmp_images("R8 restore ECC bit-exact", 1'b1);
    chk(status[3:0] == 4'b0100 && !iso_open, "R8 back to normal", {status[3:0], iso_open}, 5'b01000);

    // R6 timeout: no words move
    sr_ack = 1'b1;
    @(negedge clk); save_req_n = 1'b0;
    wait_busy(seen);
    k = 0;
    save_req_n = 1'b1;
    while (k < BUD - 1) begin tick(); k++; end
    chk(status[1:0] == 2'b01 && status[3], "R6 still saving in last cycle", status, 5'b01001);
    chk(status[2] == 1'b0, "R3 valid cleared at save start", status[2], 0);
    tick();
    chk(status == 5'b10011, "R6 timeout status", status, 5'b10011);
    sr_ack = 1'b0;
    tick();
    chk(status[1:0] == 2'b00 && !dram_wr_valid, "R7 no restore without image", status, 0);

    // R6 boundary: last word in final budget cycle succeeds
    new_image();
    pwr_good = 1'b0;
    sr_ack = 1'b1;
    @(negedge clk); save_req_n = 1'b0;
    wait_busy(seen);
    chk(status[4] == 1'b0, "R3 error cleared on new save", status[4], 0);
    k = 0;
    save_req_n = 1'b1;
    tick(); k++;
    for (int i = 0; i < NW - 1; i++) begin
      @(negedge clk); k++;
      dram_rd_valid = 1'b1; dram_rd_data = dram_img[i]; nand_wr_ready = 1'b1;
      #1; nand_img[i] = nand_wr_data;
    end
    @(negedge clk); k++;
    dram_rd_valid = 1'b1; dram_rd_data = dram_img[NW-1]; nand_wr_ready = 1'b0;
    while (k < BUD - 1) begin @(negedge clk); k++; end
    nand_wr_ready = 1'b1;
    #1; nand_img[NW-1] = nand_wr_data;
    @(negedge clk); dram_rd_valid = 1'b0; nand_wr_ready = 1'b0; #1;
    chk(status == 5'b00111, "R6 last-cycle completion wins", status, 5'b00111);
    cmp_images("R4 boundary save bit-exact", 1'b0);
    sr_ack = 1'b0;

    // R9 request during restore aborts it
    pwr_good = 1'b1;
    wait_mode(2'b10, "R7 restore after boundary save");
    pump_restore(5);
    new_image();
    @(negedge clk); save_req_n = 1'b0;
    wait_mode(2'b01, "R9 abort enters save");
    chk(status[2] == 1'b1 && iso_open, "R9 valid kept, bus isolated", {status[2], iso_open}, 2'b11);
    save_req_n = 1'b1;
    pump_save(NW, 1'b1);
    chk(status[2] == 1'b1 && status[4] == 1'b0, "R9 new save valid", status, 5'b00111);
    cmp_images("R4 post-abort save bit-exact", 1'b0);
    wait_mode(2'b10, "R7 restore of new image");
    pump_restore(NW);
    cmp_images("R8 post-abort restore bit-exact", 1'b1);
    chk(status[1:0] == 2'b00 && !iso_open, "R8 normal after restore", status, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule